// File: doc/BRIEF.md
# Burst Cache SRAM Address Sequencer

This block is the address and control front end of a synchronous burst cache memory. On every rising clock edge it samples a word address, two address strobes (one for the processor, one for the cache controller), an advance input, a write qualifier and three chip selects. It then decides whether to start a new four-beat burst, step or pause the burst in progress, or drop out of the selected state. It drives the array address for the current beat, a flag that says the device is in a burst, the registered read or write type, and the beat position.

The two low address bits seed a 2-bit beat counter and the upper bits stay fixed for the whole burst. A static order input picks between a linear order, where the low bits count up modulo 4 from the start value, and an interleaved order, where the low bits are the start value XOR the beat count. After four beats the sequence wraps to its start. The processor strobe is gated by the first chip select, takes priority over the controller strobe, and always starts a read. The controller strobe starts a read or a write as the qualifier says. Address and control carry no valid/ready handshake: each edge is one command, and nothing can apply back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: The device counts as selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0; only a selected strobe edge loads a new address, and after a load `active`=1 and `arr_addr` equals the sampled `addr_in`.
- R2: With `cs1_n`=1 the processor strobe has no effect: if `strb_ctrl_n`=1 the burst in progress continues as if both strobes were high, and if `strb_ctrl_n`=0 the block leaves the selected state.
- R3: An effective strobe (`strb_ctrl_n`=0, or `strb_proc_n`=0 with `cs1_n`=0) seen while the device is not selected drives `active` to 0.
- R4: A selected edge with `strb_proc_n`=0 loads the address and starts a read (`op_write`=0), whatever `wr_n` is.
- R5: A selected edge with `strb_proc_n`=1 and `strb_ctrl_n`=0 loads the address and starts a write (`op_write`=1) when `wr_n`=0 and a read when `wr_n`=1.
- R6: When both strobes are low on a selected edge the processor strobe wins and the burst is a read even with `wr_n`=0.
- R7: During a burst, an edge with neither strobe effective and `adv_n`=0 moves `beat_idx` to the next value modulo 4; `op_write` takes the value of `wr_n`=0 on every such continuing edge.
- R8: During a burst, an edge with neither strobe effective and `adv_n`=1 leaves `arr_addr` and `beat_idx` unchanged.
- R9: `adv_n` is ignored on a load edge: the burst always begins with `beat_idx`=0.
- R10: With `order_sel`=0 the low two address bits are the start value plus `beat_idx` modulo 4 (start 01 gives 01, 10, 11, 00).
- R11: With `order_sel`=1 the low two address bits are the start value XOR `beat_idx` (start 10 gives 10, 11, 00, 01).
- R12: The upper address bits hold for the whole burst, and after four advances the address wraps back to the start value.
- R13: A synchronous active-high `rst` sets `active`=0, `beat_idx`=0 and `op_write`=0.
- R14: A selected controller strobe during a burst abandons the old burst and loads the new address at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External word address |
| strb_proc_n | input | 1 | Processor address strobe, active low, gated by cs1_n |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_n | input | 1 | Write qualifier, active low |
| cs1_n | input | 1 | First chip select, active low |
| cs2 | input | 1 | Second chip select, active high |
| cs3_n | input | 1 | Third chip select, active low |
| order_sel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| arr_addr | output | ADDR_W | Array address of the current beat |
| active | output | 1 | Device selected and in a burst |
| op_write | output | 1 | 1 when the current cycle is a write |
| beat_idx | output | 2 | Position within the four-beat burst |

## Verification
The bench sweeps every start value in both orders through loads from either strobe, with waits inserted and a full wrap, and computes each address arithmetically; a sequencer that added where it should XOR, or that forgot to reseed, would show the wrong low bits on the second or third beat. It walks all eight chip-select patterns under each strobe from inside a burst, where a decoder that let the processor strobe through a high first select, or that continued instead of deselecting, would leave `active` high. Loads taken with advance low, both strobes low with a write qualifier, and a controller strobe in mid-burst catch a counter that steps on the load edge, a priority reversed, or an old burst that survives a reload. A long random run against an independent model covers the mixed cases.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_DESEL,
    CMD_LOAD_RD,
    CMD_LOAD_WR,
    CMD_STEP,
    CMD_HOLD
  } seq_cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_seq_pkg::*;
(
  input  logic     strb_proc_n,
  input  logic     strb_ctrl_n,
  input  logic     adv_n,
  input  logic     wr_n,
  input  logic     cs1_n,
  input  logic     cs2,
  input  logic     cs3_n,
  input  logic     busy,
  output logic     selected,
  output seq_cmd_e cmd
);
  logic proc_eff;

  assign selected = !cs1_n && cs2 && !cs3_n;
  // processor strobe only counts with the first select low
  assign proc_eff = !strb_proc_n && !cs1_n;

  always_comb begin
    cmd = CMD_IDLE;
    if (proc_eff) begin
      cmd = selected ? CMD_LOAD_RD : CMD_DESEL;
    end else if (!strb_ctrl_n) begin
      if (!selected)  cmd = CMD_DESEL;
      else if (!wr_n) cmd = CMD_LOAD_WR;
      else            cmd = CMD_LOAD_RD;
    end else if (busy) begin
      cmd = adv_n ? CMD_HOLD : CMD_STEP;
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [BEAT_W-1:0] seed,
  input  logic              order_sel,
  output logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] lsb
);
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_q <= '0;
    end else if (load) begin
      cnt_q   <= '0;
      start_q <= seed;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign beat = cnt_q;
  assign lsb  = order_sel ? (start_q ^ cnt_q) : (start_q + cnt_q);

  assert_load_beat0_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat == '0));
  assert_step_next_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (beat == BEAT_W'($past(beat) + 1'b1)));
  assert_no_step_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(beat));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic              wr_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              active,
  output logic              op_write,
  output logic [1:0]        beat_idx
);
  localparam int BEAT_W = 2;
  localparam int UP_W   = ADDR_W - BEAT_W;

  seq_cmd_e          cmd;
  logic              selected;
  logic              load;
  logic              step;
  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] lsb;
  logic              act_q;
  logic              wr_q;

  burst_cmd_decode u_dec (
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .adv_n       (adv_n),
    .wr_n        (wr_n),
    .cs1_n       (cs1_n),
    .cs2         (cs2),
    .cs3_n       (cs3_n),
    .busy        (act_q),
    .selected    (selected),
    .cmd         (cmd)
  );

  assign load = (cmd == CMD_LOAD_RD) || (cmd == CMD_LOAD_WR);
  assign step = (cmd == CMD_STEP);

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .seed      (addr_in[BEAT_W-1:0]),
    .order_sel (order_sel),
    .beat      (beat_idx),
    .lsb       (lsb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      upper_q <= '0;
    end else begin
      case (cmd)
        CMD_DESEL: begin
          act_q <= 1'b0;
          wr_q  <= 1'b0;
        end
        CMD_LOAD_RD, CMD_LOAD_WR: begin
          act_q   <= 1'b1;
          wr_q    <= (cmd == CMD_LOAD_WR);
          upper_q <= addr_in[ADDR_W-1:BEAT_W];
        end
        CMD_STEP, CMD_HOLD: wr_q <= !wr_n;
        default: ;
      endcase
    end
  end

  assign arr_addr = {upper_q, lsb};
  assign active   = act_q;
  assign op_write = wr_q;

  assert_load_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (selected && (!strb_ctrl_n || (!strb_proc_n && !cs1_n)))
      |=> (active && arr_addr == $past(addr_in)));
  assert_blocked_proc_R2: assert property (@(posedge clk) disable iff (rst)
    (active && cs1_n && strb_ctrl_n) |=> (active && $stable(upper_q)));
  assert_unsel_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (!selected && (!strb_ctrl_n || (!strb_proc_n && !cs1_n))) |=> !active);
  assert_proc_read_R4: assert property (@(posedge clk) disable iff (rst)
    (selected && !strb_proc_n) |=> (active && !op_write));
  assert_ctrl_type_R5: assert property (@(posedge clk) disable iff (rst)
    (selected && strb_proc_n && !strb_ctrl_n) |=> (op_write == $past(!wr_n)));
  assert_hold_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_HOLD) |=> $stable(arr_addr));
  assert_upper_fixed_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STEP || cmd == CMD_HOLD) |=> $stable(upper_q));
  assert_reset_state_R13: assert property (@(posedge clk)
    rst |=> (!active && beat_idx == 2'd0 && !op_write));
endmodule

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic [AW-1:0] addr_in;
  logic          strb_proc_n, strb_ctrl_n, adv_n, wr_n;
  logic          cs1_n, cs2, cs3_n, order_sel;
  logic [AW-1:0] arr_addr;
  logic          active, op_write;
  logic [1:0]    beat_idx;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .adv_n(adv_n), .wr_n(wr_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .order_sel(order_sel), .arr_addr(arr_addr), .active(active),
    .op_write(op_write), .beat_idx(beat_idx)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  bit            m_act, m_wr;
  logic [AW-3:0] m_up;
  logic [1:0]    m_start, m_cnt;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] l;
    l = order_sel ? (m_start ^ m_cnt) : 2'(m_start + m_cnt);
    return {m_up, l};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic p_n, input logic c_n, input logic av_n, input logic w_n,
                     input logic s1_n, input logic s2, input logic s3_n,
                     input logic [AW-1:0] a, input string req);
    bit sel;
    strb_proc_n = p_n; strb_ctrl_n = c_n; adv_n = av_n; wr_n = w_n;
    cs1_n = s1_n; cs2 = s2; cs3_n = s3_n; addr_in = a;
    sel = !s1_n && s2 && !s3_n;
    if (!p_n && !s1_n) begin
      if (sel) begin m_act = 1; m_wr = 0; m_up = a[AW-1:2]; m_start = a[1:0]; m_cnt = 0; end
      else begin m_act = 0; m_wr = 0; end
    end else if (!c_n) begin
      if (sel) begin m_act = 1; m_wr = !w_n; m_up = a[AW-1:2]; m_start = a[1:0]; m_cnt = 0; end
      else begin m_act = 0; m_wr = 0; end
    end else if (m_act) begin
      if (!av_n) m_cnt = m_cnt + 2'd1;
      m_wr = !w_n;
    end
    @(posedge clk); #1;
    chk(req, "active", int'(active), int'(m_act));
    if (m_act) begin
      chk(req, "arr_addr", int'(arr_addr), int'(m_addr()));
      chk(req, "beat_idx", int'(beat_idx), int'(m_cnt));
      chk(req, "op_write", int'(op_write), int'(m_wr));
    end
  endtask

  // shorthands: selected processor load, selected controller load, continue
  task automatic ld_p(input logic [AW-1:0] a, input logic av, input logic w, input string req);
    cyc(0, 1, av, w, 0, 1, 0, a, req);
  endtask
  task automatic ld_c(input logic [AW-1:0] a, input logic w, input string req);
    cyc(1, 0, 1, w, 0, 1, 0, a, req);
  endtask
  task automatic go(input logic av, input logic w, input string req);
    cyc(1, 1, av, w, 0, 1, 0, '0, req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; addr_in = '0; strb_proc_n = 1; strb_ctrl_n = 1; adv_n = 1; wr_n = 1;
    cs1_n = 1; cs2 = 0; cs3_n = 1; order_sel = 0;
    m_act = 0; m_wr = 0; m_up = '0; m_start = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R13", "active", int'(active), 0);
    chk("R13", "beat_idx", int'(beat_idx), 0);
    chk("R13", "op_write", int'(op_write), 0);
    rst = 0;

    // R10 explicit linear sequence from start 01
    order_sel = 0;
    ld_p(6'b101_1_01, 1, 1, "R1");
    chk("R10", "lsb b0", int'(arr_addr[1:0]), 1);
    go(0, 1, "R10"); chk("R10", "lsb b1", int'(arr_addr[1:0]), 2);
    go(0, 1, "R10"); chk("R10", "lsb b2", int'(arr_addr[1:0]), 3);
    go(0, 1, "R10"); chk("R10", "lsb b3", int'(arr_addr[1:0]), 0);
    go(0, 1, "R12"); chk("R12", "wrap", int'(arr_addr), int'(6'b101_1_01));

    // R11 explicit interleaved sequence from start 10
    cyc(1, 0, 1, 1, 1, 0, 0, '0, "R3");
    order_sel = 1;
    ld_c(6'b011_0_10, 1, "R5");
    chk("R11", "lsb b0", int'(arr_addr[1:0]), 2);
    go(0, 1, "R11"); chk("R11", "lsb b1", int'(arr_addr[1:0]), 3);
    go(0, 1, "R11"); chk("R11", "lsb b2", int'(arr_addr[1:0]), 0);
    go(0, 1, "R11"); chk("R11", "lsb b3", int'(arr_addr[1:0]), 1);

    // sweep: order x start x strobe/type, with a wait and a wrap
    for (int o = 0; o < 2; o++) begin
      cyc(1, 0, 1, 1, 1, 1, 0, '0, "R3");
      order_sel = o[0];
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 3; k++) begin
          logic [AW-1:0] a;
          a = {4'(s * 5 + k + o * 3), 2'(s)};
          if (k == 0)      ld_p(a, 0, 0, "R4");
          else if (k == 1) ld_c(a, 0, "R5");
          else             ld_c(a, 1, "R5");
          chk("R9", "beat at load", int'(beat_idx), 0);
          go(0, k[0], (o == 0) ? "R10" : "R11");
          go(0, 1, "R7");
          go(1, 0, "R8");
          go(1, 1, "R8");
          go(0, 0, "R7");
          go(0, 1, "R12");
          chk("R12", "wrap to start", int'(arr_addr), int'(a));
        end
      end
    end

    // R6: both strobes low with write qualifier -> read
    order_sel = 0;
    cyc(0, 0, 1, 0, 0, 1, 0, 6'h2e, "R6");
    chk("R6", "op_write", int'(op_write), 0);
    // R9: advance low on load edge
    ld_p(6'h13, 0, 1, "R9");
    go(0, 1, "R7");
    // R2: blocked processor strobe continues the burst
    cyc(0, 1, 0, 1, 1, 0, 1, 6'h3f, "R2");
    chk("R2", "still active", int'(active), 1);
    // R14: controller strobe mid-burst reloads
    ld_c(6'h21, 0, "R14");
    chk("R14", "arr_addr", int'(arr_addr), 6'h21);
    // R2: blocked processor, controller low -> deselect
    cyc(0, 0, 1, 1, 1, 1, 0, 6'h05, "R2");
    chk("R2", "deselected", int'(active), 0);

    // R3 / R1: all select patterns under each strobe, from inside a burst
    for (int cs = 0; cs < 8; cs++) begin
      for (int st = 0; st < 2; st++) begin
        ld_p(6'h1a, 1, 1, "R1");
        go(0, 1, "R7");
        if (st == 0) cyc(0, 1, 1, 1, cs[0], cs[1], cs[2], 6'h07, "R3");
        else         cyc(1, 0, 1, 1, cs[0], cs[1], cs[2], 6'h07, "R3");
      end
    end

    // mixed random run against the model
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] r;
      if (i == 1500) begin
        cyc(1, 0, 1, 1, 0, 0, 0, '0, "R3");
        order_sel = ~order_sel;
      end
      r = 10'($urandom);
      cyc(r[0] | r[7], r[1] | r[8], r[2], r[3], r[4] & r[9], r[5] | r[7], r[6] & r[8],
          6'($urandom), "R1");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule